// File: doc/BRIEF.md
# Partitioned Multi-Channel Transmit FIFO

This block holds outgoing packet data for four independent channels in one shared memory of 33-bit words. Software places each channel in its own window of that memory by giving it a base address and a size counted in blocks of 32 words. Inside its window each channel behaves as a circular queue. Every channel has its own write port, which takes data words that carry an end-of-packet marker. One read port serves whichever channel a downstream arbiter selects on `rd_ch_i`. The block holds no arbitration policy of its own.

Each channel reports full, empty, busy and fill count so the arbiter can make its choice. A channel's window can only be changed while the channel is disabled. Any accepted reconfiguration discards what the channel held. Writing a size of zero therefore flushes the channel and cuts off a read from it in the same cycle. A configuration-error flag warns when an enabled channel's size is not a multiple of the transfer threshold. A sticky interrupt bit reports the moment the last complete packet held anywhere in the block has been delivered.

Top module: `tx_chan_fifo`

## Requirements
- R1: Words read from a channel leave in the order they were written, with the 33-bit data and the end-of-packet bit intact, including when the queue wraps past the end of its window.
- R2: `wr_ready_o[i]` is 1 exactly when channel i is enabled, its window is non-empty and its fill count is below the window size. A word is stored when `wr_valid_i[i]` and `wr_ready_o[i]` are both 1. A disabled channel stores nothing.
- R3: The window of a channel holds `size*32` words, clamped to the memory depth (256), so a size of 15 gives 256 words. `full_o[i]` is 1 when the fill count has reached the window size. A size of 0 reads as full.
- R4: A configuration write (`cfg_we_i` with `cfg_ch_i` = i) made while `en_i[i]` is 1 is ignored: the window and the stored words are unchanged.
- R5: A configuration write to a disabled channel loads the new base and size, and from the next cycle the channel is empty with its queue restarted at the base.
- R6: In the cycle of a configuration write to the disabled channel selected by `rd_ch_i`, `rd_valid_o` is 0 and no word is taken from it.
- R7: `rd_valid_o` is 1 when the channel selected by `rd_ch_i` holds at least one word. `rd_data_o` and `rd_eop_o` show its oldest word, and `rd_req_i` with `rd_valid_o` removes that word at the clock edge.
- R8: `count_o[9*i +: 9]` gives the number of words held by channel i. `busy_o[i]` is 1 while that number is non-zero, and `empty_o[i]` is 1 when it is zero.
- R9: `irq_o` goes to 1 in the cycle after a word with end-of-packet is read, if no channel then holds a complete packet. It stays at 1 until `irq_clr_i` is 1 at a clock edge with no new set event; a set event wins over the clear.
- R10: `cfg_err_o[i]` is 1 when channel i is enabled, `thr_i` is non-zero and the channel's size is not a multiple of `thr_i`. `thr_i` is counted in the same 32-word units as the size.
- R11: After reset every channel has base 0 and size 0, is empty, is not ready, and `irq_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 4 | Per-channel enable |
| thr_i | input | 3 | Transfer threshold in 32-word units, 0 = none |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_ch_i | input | 2 | Channel addressed by the configuration write |
| cfg_start_i | input | 8 | Window base address |
| cfg_size_i | input | 4 | Window size in 32-word units |
| wr_valid_i | input | 4 | Per-channel write valid |
| wr_eop_i | input | 4 | Per-channel end-of-packet marker |
| wr_data_i | input | 132 | Per-channel 33-bit write data, channel i at [33*i +: 33] |
| wr_ready_o | output | 4 | Per-channel write ready |
| rd_ch_i | input | 2 | Channel selected for reading |
| rd_req_i | input | 1 | Read request, pops when valid |
| rd_valid_o | output | 1 | Selected channel has a word |
| rd_eop_o | output | 1 | End-of-packet bit of the read word |
| rd_data_o | output | 33 | Read data |
| busy_o | output | 4 | Channel holds unsent words |
| full_o | output | 4 | Channel window is full |
| empty_o | output | 4 | Channel holds nothing |
| count_o | output | 36 | Per-channel fill count, channel i at [9*i +: 9] |
| cfg_err_o | output | 4 | Size is not a multiple of the threshold |
| irq_clr_i | input | 1 | Clear the packet-sent status |
| irq_o | output | 1 | Packet-sent status |

## Verification
On every cycle the assertions check these rules: a disabled or full channel is never ready, a read is never valid from an empty channel, a flushing write on the selected channel blocks the read in that cycle, a channel is empty right after a reload, and the interrupt only rises after an end-of-packet word has been delivered. The behavioural queue model in the bench is the only thing that can show the rest. That covers data order and integrity across window wraparound, the clamping of large sizes to the memory depth, the ignored write to an enabled channel, and the exact cycle at which the last pending packet sets the interrupt.

// File: rtl/tx_fifo_pkg.sv
package tx_fifo_pkg;
  localparam int unsigned DEF_DEPTH = 256;
  localparam int unsigned DEF_UNIT  = 32;
  localparam int unsigned DEF_DW    = 33;

  // window in words, clamped to memory depth
  function automatic int unsigned win_words(int unsigned size, int unsigned unit,
                                            int unsigned depth);
    int unsigned w;
    w = size * unit;
    return (w > depth) ? depth : w;
  endfunction
endpackage

// File: rtl/tx_word_store.sv
module tx_word_store #(
  parameter int unsigned DEPTH = 256,
  parameter int unsigned EW    = 34,
  parameter int unsigned N_WR  = 4,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic               clk_i,
  input  logic [N_WR-1:0]    we_i,
  input  logic [N_WR*AW-1:0] waddr_i,
  input  logic [N_WR*EW-1:0] wdata_i,
  input  logic [AW-1:0]      raddr_i,
  output logic [EW-1:0]      rdata_o
);
  logic [EW-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    for (int i = 0; i < int'(N_WR); i++) begin
      if (we_i[i]) mem[waddr_i[i*AW +: AW]] <= wdata_i[i*EW +: EW];
    end
  end

  assign rdata_o = mem[raddr_i];
endmodule

// File: rtl/tx_chan_ctrl.sv
module tx_chan_ctrl #(
  parameter int unsigned DEPTH  = 256,
  parameter int unsigned UNIT   = 32,
  parameter int unsigned SIZE_W = 4,
  localparam int unsigned AW    = $clog2(DEPTH),
  localparam int unsigned CW    = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              load_i,
  input  logic [AW-1:0]     start_i,
  input  logic [SIZE_W-1:0] size_i,
  input  logic              push_req_i,
  input  logic              push_eop_i,
  input  logic              pop_i,
  input  logic              pop_eop_i,
  output logic              push_o,
  output logic              ready_o,
  output logic [AW-1:0]     wr_addr_o,
  output logic [AW-1:0]     rd_addr_o,
  output logic [SIZE_W-1:0] size_o,
  output logic              full_o,
  output logic              empty_o,
  output logic [CW-1:0]     count_o,
  output logic [CW-1:0]     pkt_nxt_o
);
  logic [AW-1:0]     start_q;
  logic [SIZE_W-1:0] size_q;
  logic [CW-1:0]     woff_q, roff_q, cnt_q, pkt_q, win;

  assign win       = CW'(tx_fifo_pkg::win_words(int'(size_q), UNIT, DEPTH));
  assign ready_o   = en_i && (cnt_q < win);
  assign push_o    = push_req_i && ready_o;
  assign full_o    = (cnt_q >= win);
  assign empty_o   = (cnt_q == '0);
  assign count_o   = cnt_q;
  assign size_o    = size_q;
  assign wr_addr_o = start_q + AW'(woff_q);
  assign rd_addr_o = start_q + AW'(roff_q);

  always_comb begin
    if (load_i) pkt_nxt_o = '0;
    else pkt_nxt_o = pkt_q + CW'(push_o && push_eop_i) - CW'(pop_i && pop_eop_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      start_q <= '0;
      size_q  <= '0;
      woff_q  <= '0;
      roff_q  <= '0;
      cnt_q   <= '0;
      pkt_q   <= '0;
    end else if (load_i) begin
      start_q <= start_i;
      size_q  <= size_i;
      woff_q  <= '0;
      roff_q  <= '0;
      cnt_q   <= '0;
      pkt_q   <= '0;
    end else begin
      if (push_o) woff_q <= (woff_q == win - 1'b1) ? '0 : woff_q + 1'b1;
      if (pop_i)  roff_q <= (roff_q == win - 1'b1) ? '0 : roff_q + 1'b1;
      cnt_q <= cnt_q + CW'(push_o) - CW'(pop_i);
      pkt_q <= pkt_nxt_o;
    end
  end
endmodule

// File: rtl/tx_chan_fifo.sv
module tx_chan_fifo #(
  parameter int unsigned N_CH   = 4,
  parameter int unsigned DW     = tx_fifo_pkg::DEF_DW,
  parameter int unsigned DEPTH  = tx_fifo_pkg::DEF_DEPTH,
  parameter int unsigned UNIT   = tx_fifo_pkg::DEF_UNIT,
  parameter int unsigned THR_W  = 3,
  localparam int unsigned AW    = $clog2(DEPTH),
  localparam int unsigned CW    = $clog2(DEPTH + 1),
  localparam int unsigned SIZE_W = $clog2(DEPTH / UNIT) + 1,
  localparam int unsigned CHW   = $clog2(N_CH)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_CH-1:0]    en_i,
  input  logic [THR_W-1:0]   thr_i,
  input  logic               cfg_we_i,
  input  logic [CHW-1:0]     cfg_ch_i,
  input  logic [AW-1:0]      cfg_start_i,
  input  logic [SIZE_W-1:0]  cfg_size_i,
  input  logic [N_CH-1:0]    wr_valid_i,
  input  logic [N_CH-1:0]    wr_eop_i,
  input  logic [N_CH*DW-1:0] wr_data_i,
  output logic [N_CH-1:0]    wr_ready_o,
  input  logic [CHW-1:0]     rd_ch_i,
  input  logic               rd_req_i,
  output logic               rd_valid_o,
  output logic               rd_eop_o,
  output logic [DW-1:0]      rd_data_o,
  output logic [N_CH-1:0]    busy_o,
  output logic [N_CH-1:0]    full_o,
  output logic [N_CH-1:0]    empty_o,
  output logic [N_CH*CW-1:0] count_o,
  output logic [N_CH-1:0]    cfg_err_o,
  input  logic               irq_clr_i,
  output logic               irq_o
);
  localparam int unsigned EW = DW + 1;
  localparam int unsigned MW = (SIZE_W > THR_W) ? SIZE_W : THR_W;
  localparam int unsigned TW = CW + CHW;

  logic [N_CH-1:0]      load, push, pop;
  logic [N_CH*AW-1:0]   waddr, raddr;
  logic [N_CH*EW-1:0]   wdata;
  logic [N_CH*CW-1:0]   pkt_nxt;
  logic [N_CH*SIZE_W-1:0] size_w;
  logic [EW-1:0]        rword;
  logic [TW-1:0]        pkt_total;
  logic                 deliver, irq_q;

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    assign load[g]         = cfg_we_i && (cfg_ch_i == CHW'(g)) && !en_i[g];
    assign pop[g]          = rd_req_i && rd_valid_o && (rd_ch_i == CHW'(g));
    assign wdata[g*EW +: EW] = {wr_eop_i[g], wr_data_i[g*DW +: DW]};
    assign busy_o[g]       = !empty_o[g];
    assign cfg_err_o[g]    = en_i[g] && (thr_i != '0) &&
                             ((MW'(size_w[g*SIZE_W +: SIZE_W]) % MW'(thr_i)) != '0);

    tx_chan_ctrl #(.DEPTH(DEPTH), .UNIT(UNIT), .SIZE_W(SIZE_W)) ctrl_i (
      .clk_i, .rst_ni,
      .en_i      (en_i[g]),
      .load_i    (load[g]),
      .start_i   (cfg_start_i),
      .size_i    (cfg_size_i),
      .push_req_i(wr_valid_i[g]),
      .push_eop_i(wr_eop_i[g]),
      .pop_i     (pop[g]),
      .pop_eop_i (rd_eop_o),
      .push_o    (push[g]),
      .ready_o   (wr_ready_o[g]),
      .wr_addr_o (waddr[g*AW +: AW]),
      .rd_addr_o (raddr[g*AW +: AW]),
      .size_o    (size_w[g*SIZE_W +: SIZE_W]),
      .full_o    (full_o[g]),
      .empty_o   (empty_o[g]),
      .count_o   (count_o[g*CW +: CW]),
      .pkt_nxt_o (pkt_nxt[g*CW +: CW])
    );
  end

  tx_word_store #(.DEPTH(DEPTH), .EW(EW), .N_WR(N_CH)) store_i (
    .clk_i,
    .we_i   (push),
    .waddr_i(waddr),
    .wdata_i(wdata),
    .raddr_i(raddr[rd_ch_i*AW +: AW]),
    .rdata_o(rword)
  );

  // reconfiguring the selected channel kills the read in the same cycle
  assign rd_valid_o = !empty_o[rd_ch_i] && !load[rd_ch_i];
  assign rd_data_o  = rword[DW-1:0];
  assign rd_eop_o   = rword[DW];
  assign deliver    = rd_valid_o && rd_req_i && rd_eop_o;

  always_comb begin
    pkt_total = '0;
    for (int i = 0; i < int'(N_CH); i++) pkt_total = pkt_total + TW'(pkt_nxt[i*CW +: CW]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else if (deliver && pkt_total == '0) irq_q <= 1'b1;
    else if (irq_clr_i) irq_q <= 1'b0;
  end
  assign irq_o = irq_q;
endmodule

// File: rtl/tx_chan_fifo_chk.sv
module tx_chan_fifo_chk #(
  parameter int unsigned N_CH  = 4,
  parameter int unsigned DEPTH = 256,
  localparam int unsigned CW   = $clog2(DEPTH + 1),
  localparam int unsigned CHW  = $clog2(N_CH)
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [N_CH-1:0]    en_i,
  input logic               cfg_we_i,
  input logic [CHW-1:0]     cfg_ch_i,
  input logic [N_CH-1:0]    wr_ready_o,
  input logic [CHW-1:0]     rd_ch_i,
  input logic               rd_req_i,
  input logic               rd_valid_o,
  input logic               rd_eop_o,
  input logic [N_CH-1:0]    full_o,
  input logic [N_CH-1:0]    empty_o,
  input logic [N_CH*CW-1:0] count_o,
  input logic               irq_o
);
  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    // R2
    off_no_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !en_i[g] |-> !wr_ready_o[g]);
    // R3
    no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      full_o[g] |-> !wr_ready_o[g]);
    // R5
    reload_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cfg_we_i && cfg_ch_i == CHW'(g) && !en_i[g]) |=> (empty_o[g] && count_o[g*CW +: CW] == '0));
  end

  // R7
  rd_nonempty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> !empty_o[rd_ch_i]);
  // R6
  flush_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && cfg_ch_i == rd_ch_i && !en_i[rd_ch_i]) |-> !rd_valid_o);
  // R9
  irq_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(rd_valid_o && rd_req_i && rd_eop_o));
endmodule

bind tx_chan_fifo tx_chan_fifo_chk #(.N_CH(N_CH), .DEPTH(DEPTH)) chk_i (.*);

// File: tb/tx_chan_fifo_tb_top.sv
module tx_chan_fifo_tb_top;
  localparam int NC = 4, DW = 33, CW = 9;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic [3:0] en_i = '0, wr_valid_i = '0, wr_eop_i = '0;
  logic [2:0] thr_i = '0;
  logic cfg_we_i = 1'b0, rd_req_i = 1'b0, irq_clr_i = 1'b0;
  logic [1:0] cfg_ch_i = '0, rd_ch_i = '0;
  logic [7:0] cfg_start_i = '0;
  logic [3:0] cfg_size_i = '0;
  logic [NC*DW-1:0] wr_data_i = '0;
  logic [3:0] wr_ready_o, busy_o, full_o, empty_o, cfg_err_o;
  logic rd_valid_o, rd_eop_o, irq_o;
  logic [DW-1:0] rd_data_o;
  logic [NC*CW-1:0] count_o;

  always #5 clk_i = ~clk_i;

  tx_chan_fifo dut_i (.*);

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [33:0] mq [4][$];
  int msize [4] = '{default: 0};
  int mpkt [4] = '{default: 0};
  bit mirq = 0;
  bit load [4], rdy [4], vld;

  task automatic chk(bit ok, string tag, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int win(int ch);
    int w = msize[ch] * 32;
    return (w > 256) ? 256 : w;
  endfunction

  function automatic int cnt(int ch);
    return int'(count_o[ch*CW +: CW]);
  endfunction

  task automatic compare();
    for (int i = 0; i < 4; i++) begin
      int w = win(i);
      load[i] = cfg_we_i && cfg_ch_i == 2'(i) && !en_i[i];
      rdy[i]  = en_i[i] && w != 0 && mq[i].size() < w;
      chk(wr_ready_o[i] == rdy[i], "R2 ready", wr_ready_o[i], rdy[i]);
      chk(full_o[i] == (mq[i].size() >= w), "R3 full", full_o[i], mq[i].size() >= w);
      chk(cnt(i) == mq[i].size(), "R8 count", cnt(i), mq[i].size());
      chk(busy_o[i] == (mq[i].size() != 0), "R8 busy", busy_o[i], mq[i].size() != 0);
      chk(empty_o[i] == (mq[i].size() == 0), "R8 empty", empty_o[i], mq[i].size() == 0);
      chk(cfg_err_o[i] == (en_i[i] && thr_i != 0 && (msize[i] % int'(thr_i)) != 0),
          "R10 cfg_err", cfg_err_o[i],
          en_i[i] && thr_i != 0 && (msize[i] % int'(thr_i)) != 0);
    end
    vld = mq[rd_ch_i].size() > 0 && !load[rd_ch_i];
    chk(rd_valid_o == vld, load[rd_ch_i] ? "R6 valid" : "R7 valid", rd_valid_o, vld);
    if (vld && rd_valid_o)
      chk({rd_eop_o, rd_data_o} == mq[rd_ch_i][0], "R1 data", {rd_eop_o, rd_data_o},
          mq[rd_ch_i][0]);
    chk(irq_o == mirq, "R9 irq", irq_o, mirq);
  endtask

  task automatic update();
    bit deliv = 0;
    int tot = 0;
    for (int i = 0; i < 4; i++) begin
      if (load[i]) begin
        msize[i] = int'(cfg_size_i);
        mq[i].delete();
        mpkt[i] = 0;
      end else begin
        if (vld && rd_req_i && rd_ch_i == 2'(i)) begin
          logic [33:0] w = mq[i].pop_front();
          if (w[33]) begin mpkt[i]--; deliv = 1; end
        end
        if (wr_valid_i[i] && rdy[i]) begin
          mq[i].push_back({wr_eop_i[i], wr_data_i[i*DW +: DW]});
          if (wr_eop_i[i]) mpkt[i]++;
        end
      end
      tot += mpkt[i];
    end
    if (deliv && tot == 0) mirq = 1;
    else if (irq_clr_i) mirq = 0;
  endtask

  task automatic cycle();
    #1 compare();
    @(posedge clk_i);
    update();
    @(negedge clk_i);
  endtask

  task automatic rand_data();
    for (int i = 0; i < 4; i++) wr_data_i[i*DW +: DW] = {$urandom_range(0, 1), $urandom()};
  endtask

  task automatic cfg(int ch, int start, int size);
    cfg_we_i = 1; cfg_ch_i = 2'(ch); cfg_start_i = 8'(start); cfg_size_i = 4'(size);
    cycle();
    cfg_we_i = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk_i);
    rst_ni = 1;
    // R11 reset state
    #1;
    chk(wr_ready_o == 4'h0 && empty_o == 4'hF && irq_o == 0 && count_o == '0,
        "R11 reset", {wr_ready_o, empty_o, irq_o}, {4'h0, 4'hF, 1'b0});
    cycle();

    // windows: ch0 0/1, ch1 32/2, ch2 96/4, ch3 224/1
    thr_i = 3'd1;
    cfg(0, 0, 1); cfg(1, 32, 2); cfg(2, 96, 4); cfg(3, 224, 1);
    en_i = 4'hF;

    // R1 R7 random traffic with wraparound
    for (int n = 0; n < 3000; n++) begin
      rand_data();
      wr_valid_i = 4'($urandom());
      for (int i = 0; i < 4; i++) wr_eop_i[i] = ($urandom_range(0, 3) == 0);
      rd_ch_i   = 2'($urandom());
      rd_req_i  = ($urandom_range(0, 9) < 7);
      irq_clr_i = ($urandom_range(0, 15) == 0);
      cycle();
    end
    irq_clr_i = 0;

    // R3 fill every channel
    rd_req_i = 0;
    for (int n = 0; n < 300; n++) begin
      rand_data(); wr_valid_i = 4'hF; wr_eop_i = 4'($urandom()); cycle();
    end
    wr_valid_i = 0;
    chk(cnt(1) == 64 && full_o[1], "R3 ch1 full at 64", cnt(1), 64);

    // R4 write to enabled channel ignored
    cfg(1, 0, 0);
    cycle();
    chk(cnt(1) == 64 && full_o[1] && !empty_o[1], "R4 ignored cfg", cnt(1), 64);

    // R10 threshold
    thr_i = 3'd3; cycle();
    chk(cfg_err_o == 4'hF, "R10 thr3", cfg_err_o, 4'hF);
    thr_i = 3'd2; cycle();
    chk(cfg_err_o == 4'b1001, "R10 thr2", cfg_err_o, 4'b1001);
    thr_i = 3'd1;

    // R6 flush mid read
    rd_ch_i = 2; rd_req_i = 1;
    repeat (3) cycle();
    en_i[2] = 0; cycle();
    cfg_we_i = 1; cfg_ch_i = 2; cfg_start_i = 96; cfg_size_i = 0;
    #1 chk(rd_valid_o == 0, "R6 flush blocks read", rd_valid_o, 0);
    cycle(); cfg_we_i = 0;
    #1 chk(cnt(2) == 0 && empty_o[2] && !wr_ready_o[2], "R5 flushed", cnt(2), 0);
    cycle();
    cfg(2, 96, 4); en_i[2] = 1;

    // R9 drain everything
    for (int n = 0; n < 400; n++) begin
      rd_ch_i = 2'(n % 4); cycle();
    end
    rd_req_i = 0;
    chk(empty_o == 4'hF, "R8 drained", empty_o, 4'hF);
    irq_clr_i = 1; cycle(); irq_clr_i = 0;
    #1 chk(irq_o == 0, "R9 cleared", irq_o, 0);
    cycle();

    // R5 R3 reload ch0 with size 15 (clamped to 256)
    en_i = 0; cycle();
    cfg(1, 0, 0); cfg(2, 0, 0); cfg(3, 0, 0); cfg(0, 0, 15);
    en_i = 4'b0001;
    for (int n = 0; n < 270; n++) begin
      rand_data(); wr_valid_i = 4'b0001; wr_eop_i = 4'((n % 8) == 7); cycle();
    end
    wr_valid_i = 0;
    chk(cnt(0) == 256 && full_o[0], "R3 clamp 256", cnt(0), 256);
    rd_ch_i = 0; rd_req_i = 1;
    for (int n = 0; n < 260; n++) cycle();
    rd_req_i = 0; cycle();
    chk(irq_o == 1, "R9 set after last packet", irq_o, 1);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule